// File: doc/BRIEF.md
# Flash Security Command Controller

This controller sits between a simple write bus and a small on-chip flash array model. Multi-write command sequences, each opened by two fixed unlock writes, start embedded algorithms. These algorithms program a single word, erase the whole array, or set or clear a non-volatile security bit. While an algorithm runs, the block reports busy and drops every bus write. After a clean verify it goes back to read mode by itself and pulses done. A failed verify leaves it stuck in the embedded state with fail raised, and only a reset clears that state.

The security bit decides what the off-board requester type sees on reads. The control bit `fse` has two jobs. It arms the security commands, and it decides whether the on-board CPU may read the array. The sequence that clears security is the same six-write sequence used for a chip erase. When `fse` is 1 at the last write, the block first erases every word and verifies the array, then erases and verifies the security bit. When `fse` is 0, the same sequence performs only the array erase. Erase, program and verify each last a fixed number of cycles, set by a parameter. The input `fault_inj` forces a verify step to fail so that the stuck path can be exercised.

Both data ports are valid/ready. The write port never applies back-pressure, so `wr_ready` is always 1 and writes that arrive during an operation are accepted and then discarded. The read port holds `rd_ready` low for as long as an embedded operation or a stuck failure lasts. A read accepted in cycle n returns `rsp_valid` with its data in cycle n+1, and the response has no back-pressure. Reset is synchronous and active low.

Top module: `flash_guard_ctrl`

## Requirements
- R1: A command write matches only if its address equals 0x555 or 0x2AA as expected and its data bits [7:0] equal the expected code. Every sequence opens with 0xAA to 0x555 and then 0x55 to 0x2AA. A write that deviates returns the decoder to idle, and no operation starts from what has been collected so far.
- R2: The security-on command is the unlock pair followed by 0x50 to 0x555 and then 0x20 to 0x555. If `fse` is 1 at the fourth write, `busy` rises in the next cycle and stays high for 2·STEP_CYCLES cycles. The first step sets `sec_on` at its end, and the second step verifies it.
- R3: The security-on command issued with `fse` at 0 at its fourth write has no effect: `busy` stays low and `sec_on` keeps its value.
- R4: The erase command is the unlock pair, then 0x80 to 0x555, the unlock pair again, and then 0x10 to 0x555. With `fse` at 1 at the sixth write, this takes 4·STEP_CYCLES busy cycles. The steps run in this order: all words are set to 0xFFFF, the array is verified, the security bit is cleared, and the security bit is verified.
- R5: The erase command with `fse` at 0 at its sixth write sets every word to 0xFFFF in 2·STEP_CYCLES busy cycles and leaves `sec_on` unchanged.
- R6: The program command is the unlock pair, then 0xA0 to 0x555, then a fourth write whose address bits [IDX_W-1:0] select the word and whose data replaces it. It takes 2·STEP_CYCLES busy cycles.
- R7: `wr_ready` is always 1. A write accepted while `busy` is 1 changes neither the array nor the security bit, and it does not count toward any later sequence.
- R8: When an operation succeeds, `done` is high for exactly one cycle. In that cycle `busy` is already 0 and `rd_ready` is already 1.
- R9: If `fault_inj` is 1 in the last cycle of any verify step, the block stays stuck with `busy` and `fail` both at 1 and `rd_ready` at 0 until reset, and `done` never rises.
- R10: If the array verify fails during security-off, the security bit is never cleared, so `sec_on` stays at 1.
- R11: A read with `rd_from_prog` at 1 returns 0x0098 while the security bit is set, and returns the addressed word otherwise.
- R12: A read with `rd_from_prog` at 0 returns the addressed word when `fse` is 0, whatever the security bit holds, and returns 0x0000 when `fse` is 1.
- R13: While `rst_n` is low at a clock edge, any running operation is abandoned. After that edge `busy`, `done`, `fail`, `rsp_valid` and `sec_on` are 0 and every word holds 0xFFFF.
- R14: `rd_ready` equals the inverse of `busy`. A read accepted at an edge gives `rsp_valid` at 1 in the following cycle, with data taken from the state before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Bus write valid |
| wr_ready | output | 1 | Bus write ready, always 1 |
| wr_addr | input | ADDR_W | Bus write address |
| wr_data | input | DATA_W | Bus write data |
| fse | input | 1 | Control bit that arms the security commands and blocks CPU array reads |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request ready, low while busy |
| rd_addr | input | IDX_W | Word index to read |
| rd_from_prog | input | 1 | 1 when the requester is the external programmer, 0 when it is the CPU |
| rsp_valid | output | 1 | Read response valid, one cycle after acceptance |
| rsp_data | output | DATA_W | Read response data |
| fault_inj | input | 1 | Forces a failure at the end of a verify step |
| busy | output | 1 | Embedded operation running or stuck |
| done | output | 1 | One-cycle pulse when an operation succeeds |
| fail | output | 1 | Stuck after a verify failure |
| sec_on | output | 1 | Current value of the security bit |

## Verification
The bench drives each command sequence in a clean form. It also drives three disturbed forms: a sequence broken by a wrong unlock write, the security-on sequence with `fse` at 0, and extra writes arriving while busy. Comparing the two values of `fse` on the six-write erase separates security-off from chip erase, both in the busy length and in how `sec_on` ends. Reads are repeated with both requester types and both `fse` values while the block is secured and while it is not, which exposes each branch of the read gate. Fault injection on a program verify and on the array verify of security-off shows the stuck state. In the second case it also shows that the security bit survives. A reset in the middle of an erase shows that the operation is abandoned.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

  localparam int unsigned CMD_ADDR_A = 'h555;
  localparam int unsigned CMD_ADDR_B = 'h2AA;
  localparam logic [7:0] CODE_UNLOCK_1 = 8'hAA;
  localparam logic [7:0] CODE_UNLOCK_2 = 8'h55;
  localparam logic [7:0] CODE_ERASE_ARM = 8'h80;
  localparam logic [7:0] CODE_ERASE_GO = 8'h10;
  localparam logic [7:0] CODE_LOCK_ARM = 8'h50;
  localparam logic [7:0] CODE_LOCK_GO = 8'h20;
  localparam logic [7:0] CODE_WORD_ARM = 8'hA0;
  localparam logic [15:0] LOCKED_WORD = 16'h0098;

  typedef enum logic [1:0] {
    OP_LOCK,
    OP_UNLOCK,
    OP_WIPE,
    OP_WORD
  } fg_op_e;

  typedef enum logic [2:0] {
    STP_WIPE_ARR,
    STP_CHK_ARR,
    STP_WIPE_KEY,
    STP_SET_KEY,
    STP_CHK_KEY,
    STP_PUT_WORD,
    STP_CHK_WORD
  } fg_step_e;

  function automatic fg_step_e first_step(fg_op_e op);
    case (op)
      OP_LOCK: return STP_SET_KEY;
      OP_WORD: return STP_PUT_WORD;
      default: return STP_WIPE_ARR;
    endcase
  endfunction

  function automatic fg_step_e step_after(fg_step_e s);
    case (s)
      STP_WIPE_ARR: return STP_CHK_ARR;
      STP_CHK_ARR:  return STP_WIPE_KEY;
      STP_WIPE_KEY: return STP_CHK_KEY;
      STP_SET_KEY:  return STP_CHK_KEY;
      STP_PUT_WORD: return STP_CHK_WORD;
      default:      return s;
    endcase
  endfunction

  function automatic logic is_check(fg_step_e s);
    return (s == STP_CHK_ARR) || (s == STP_CHK_KEY) || (s == STP_CHK_WORD);
  endfunction

  function automatic logic is_final(fg_op_e op, fg_step_e s);
    return (s == STP_CHK_KEY) || (s == STP_CHK_WORD) ||
           ((s == STP_CHK_ARR) && (op == OP_WIPE));
  endfunction

endpackage

// File: rtl/fg_cmd_decoder.sv
module fg_cmd_decoder
  import flash_guard_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  input  logic              fse,
  output logic              launch,
  output fg_op_e            launch_op,
  output logic [IDX_W-1:0]  word_idx,
  output logic [DATA_W-1:0] word_data
);

  localparam logic [ADDR_W-1:0] ADDR_A = ADDR_W'(CMD_ADDR_A);
  localparam logic [ADDR_W-1:0] ADDR_B = ADDR_W'(CMD_ADDR_B);

  typedef enum logic [2:0] {
    DS_IDLE, DS_UL1, DS_UL2, DS_ERASE_ARM, DS_EUL1, DS_EUL2, DS_LOCK_ARM, DS_WORD_ARM
  } dec_state_e;

  dec_state_e state_q, state_d;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] dat_q;
  logic at_a, at_b;
  logic [7:0] code;

  assign at_a = (wr_addr == ADDR_A);
  assign at_b = (wr_addr == ADDR_B);
  assign code = wr_data[7:0];

  always_comb begin
    state_d   = state_q;
    launch    = 1'b0;
    launch_op = OP_WORD;
    if (busy) begin
      state_d = DS_IDLE;
    end else if (wr_fire) begin
      state_d = DS_IDLE;
      case (state_q)
        DS_IDLE: if (at_a && code == CODE_UNLOCK_1) state_d = DS_UL1;
        DS_UL1:  if (at_b && code == CODE_UNLOCK_2) state_d = DS_UL2;
        DS_UL2: begin
          if (at_a && code == CODE_ERASE_ARM) state_d = DS_ERASE_ARM;
          else if (at_a && code == CODE_LOCK_ARM) state_d = DS_LOCK_ARM;
          else if (at_a && code == CODE_WORD_ARM) state_d = DS_WORD_ARM;
        end
        DS_ERASE_ARM: if (at_a && code == CODE_UNLOCK_1) state_d = DS_EUL1;
        DS_EUL1:      if (at_b && code == CODE_UNLOCK_2) state_d = DS_EUL2;
        DS_EUL2: begin
          if (at_a && code == CODE_ERASE_GO) begin
            launch    = 1'b1;
            launch_op = fse ? OP_UNLOCK : OP_WIPE;
          end
        end
        DS_LOCK_ARM: begin
          if (at_a && code == CODE_LOCK_GO && fse) begin
            launch    = 1'b1;
            launch_op = OP_LOCK;
          end
        end
        DS_WORD_ARM: begin
          launch    = 1'b1;
          launch_op = OP_WORD;
        end
        default: state_d = DS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= DS_IDLE;
      idx_q   <= '0;
      dat_q   <= '0;
    end else begin
      state_q <= state_d;
      if (launch && launch_op == OP_WORD) begin
        idx_q <= wr_addr[IDX_W-1:0];
        dat_q <= wr_data;
      end
    end
  end

  assign word_idx  = idx_q;
  assign word_data = dat_q;

endmodule

// File: rtl/fg_algo_seq.sv
module fg_algo_seq
  import flash_guard_pkg::*;
#(
  parameter int STEP_CYCLES = 8
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   launch,
  input  fg_op_e launch_op,
  input  logic   fault_inj,
  output logic   busy,
  output logic   done,
  output logic   fail,
  output logic   do_wipe_arr,
  output logic   do_put_word,
  output logic   do_set_key,
  output logic   do_wipe_key
);

  localparam int CNT_W = $clog2(STEP_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STEP_CYCLES - 1);

  typedef enum logic [1:0] {SQ_IDLE, SQ_RUN, SQ_STUCK} sq_state_e;

  sq_state_e         sq_q;
  fg_op_e            op_q;
  fg_step_e          step_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              done_q;
  logic              step_end;
  logic              check_bad;

  assign step_end  = (sq_q == SQ_RUN) && (cnt_q == '0);
  assign check_bad = step_end && is_check(step_q) && fault_inj;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sq_q   <= SQ_IDLE;
      op_q   <= OP_WORD;
      step_q <= STP_PUT_WORD;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (sq_q)
        SQ_IDLE: begin
          if (launch) begin
            sq_q   <= SQ_RUN;
            op_q   <= launch_op;
            step_q <= first_step(launch_op);
            cnt_q  <= CNT_LOAD;
          end
        end
        SQ_RUN: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (check_bad) begin
            sq_q <= SQ_STUCK;
          end else if (is_final(op_q, step_q)) begin
            sq_q   <= SQ_IDLE;
            done_q <= 1'b1;
          end else begin
            step_q <= step_after(step_q);
            cnt_q  <= CNT_LOAD;
          end
        end
        default: sq_q <= SQ_STUCK;
      endcase
    end
  end

  assign busy        = (sq_q != SQ_IDLE);
  assign fail        = (sq_q == SQ_STUCK);
  assign done        = done_q;
  assign do_wipe_arr = step_end && (step_q == STP_WIPE_ARR);
  assign do_put_word = step_end && (step_q == STP_PUT_WORD);
  assign do_set_key  = step_end && (step_q == STP_SET_KEY);
  assign do_wipe_key = step_end && (step_q == STP_WIPE_KEY);

endmodule

// File: rtl/fg_cell_array.sv
module fg_cell_array #(
  parameter int DATA_W = 16,
  parameter int WORDS  = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wipe_arr,
  input  logic              put_word,
  input  logic [IDX_W-1:0]  put_idx,
  input  logic [DATA_W-1:0] put_data,
  input  logic              set_key,
  input  logic              wipe_key,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_word,
  output logic              key_bit
);

  logic [DATA_W-1:0] cells [WORDS];
  logic              key_q;

  for (genvar gi = 0; gi < WORDS; gi++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n || wipe_arr) begin
        cells[gi] <= '1;
      end else if (put_word && (put_idx == IDX_W'(gi))) begin
        cells[gi] <= put_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || wipe_key) begin
      key_q <= 1'b0;
    end else if (set_key) begin
      key_q <= 1'b1;
    end
  end

  assign rd_word = cells[rd_idx];
  assign key_bit = key_q;

endmodule

// File: rtl/fg_read_gate.sv
module fg_read_gate
  import flash_guard_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fire,
  input  logic              rd_from_prog,
  input  logic              fse,
  input  logic              key_bit,
  input  logic [DATA_W-1:0] rd_word,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  logic [DATA_W-1:0] gated;

  always_comb begin
    if (rd_from_prog) gated = key_bit ? DATA_W'(LOCKED_WORD) : rd_word;
    else              gated = fse ? '0 : rd_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_fire;
      if (rd_fire) rsp_data <= gated;
    end
  end

endmodule

// File: rtl/flash_guard_ctrl.sv
module flash_guard_ctrl
  import flash_guard_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 16,
  parameter int WORDS       = 16,
  parameter int STEP_CYCLES = 8,
  localparam int IDX_W      = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              fse,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [IDX_W-1:0]  rd_addr,
  input  logic              rd_from_prog,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              fault_inj,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic              sec_on
);

  logic              launch;
  fg_op_e            launch_op;
  logic [IDX_W-1:0]  word_idx;
  logic [DATA_W-1:0] word_data;
  logic              do_wipe_arr, do_put_word, do_set_key, do_wipe_key;
  logic [DATA_W-1:0] rd_word;
  logic              key_bit;

  assign wr_ready = 1'b1;
  assign rd_ready = !busy;

  fg_cmd_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_valid && wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .fse(fse), .launch(launch),
    .launch_op(launch_op), .word_idx(word_idx), .word_data(word_data)
  );

  fg_algo_seq #(.STEP_CYCLES(STEP_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .launch(launch), .launch_op(launch_op),
    .fault_inj(fault_inj), .busy(busy), .done(done), .fail(fail),
    .do_wipe_arr(do_wipe_arr), .do_put_word(do_put_word),
    .do_set_key(do_set_key), .do_wipe_key(do_wipe_key)
  );

  fg_cell_array #(.DATA_W(DATA_W), .WORDS(WORDS), .IDX_W(IDX_W)) u_cells (
    .clk(clk), .rst_n(rst_n), .wipe_arr(do_wipe_arr), .put_word(do_put_word),
    .put_idx(word_idx), .put_data(word_data), .set_key(do_set_key),
    .wipe_key(do_wipe_key), .rd_idx(rd_addr), .rd_word(rd_word), .key_bit(key_bit)
  );

  fg_read_gate #(.DATA_W(DATA_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .rd_fire(rd_valid && rd_ready),
    .rd_from_prog(rd_from_prog), .fse(fse), .key_bit(key_bit),
    .rd_word(rd_word), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  assign sec_on = key_bit;

endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk
  import flash_guard_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              fail,
  input logic              fse,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic              rd_from_prog,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_data,
  input logic              sec_on
);

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && rd_ready)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_FAIL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> (fail && busy && !done)); // R9
  AST_NO_READ_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rd_ready); // R14
  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> rsp_valid); // R14
  AST_LOCKED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(rd_from_prog) && $past(sec_on)) |-> (rsp_data == DATA_W'(LOCKED_WORD))); // R11
  AST_CPU_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !$past(rd_from_prog) && $past(fse)) |-> (rsp_data == '0)); // R12

endmodule

bind flash_guard_ctrl flash_guard_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .fail(fail), .fse(fse),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_from_prog(rd_from_prog),
  .rsp_valid(rsp_valid), .rsp_data(rsp_data), .sec_on(sec_on)
);

// File: tb/flash_guard_ctrl_tb.sv
module flash_guard_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 16;
  localparam int WORDS  = 16;
  localparam int IDX_W  = 4;
  localparam int STEP   = 5;
  localparam int WD_LIMIT = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic fse = 1'b0;
  logic rd_valid = 1'b0;
  logic rd_ready;
  logic [IDX_W-1:0] rd_addr = '0;
  logic rd_from_prog = 1'b0;
  logic rsp_valid;
  logic [DATA_W-1:0] rsp_data;
  logic fault_inj = 1'b0;
  logic busy, done, fail, sec_on;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_guard_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .STEP_CYCLES(STEP)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .fse(fse), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_from_prog(rd_from_prog),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .fault_inj(fault_inj),
    .busy(busy), .done(done), .fail(fail), .sec_on(sec_on)
  );

  int n_checks = 0;
  int n_fails = 0;
  string cur_req = "R13";

  task automatic chk(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  bit m_busy, m_done, m_fail, m_sec, m_rsp_v, started;
  int m_rsp_d, m_op, m_e, m_widx, m_wdat;
  int m_mem[WORDS];
  int qa[$];
  int qd[$];
  // sequences: 0 lock, 1 erase, 2 word; -1 address = any write
  int seq_a[3][6] = '{'{'h555,'h2AA,'h555,'h555,0,0},
                      '{'h555,'h2AA,'h555,'h555,'h2AA,'h555},
                      '{'h555,'h2AA,'h555,-1,0,0}};
  int seq_d[3][6] = '{'{'hAA,'h55,'h50,'h20,0,0},
                      '{'hAA,'h55,'h80,'hAA,'h55,'h10},
                      '{'hAA,'h55,'hA0,0,0,0}};
  int seq_n[3] = '{4, 6, 4};

  function automatic bit is_prefix(int s);
    if (qa.size() > seq_n[s]) return 0;
    for (int i = 0; i < qa.size(); i++)
      if (seq_a[s][i] != -1 && (qa[i] != seq_a[s][i] || (qd[i] & 'hFF) != seq_d[s][i])) return 0;
    return 1;
  endfunction

  task automatic m_start(int op);
    m_busy = 1; m_op = op; m_e = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_fail = 0; m_sec = 0; m_rsp_v = 0; m_rsp_d = 0;
      for (int i = 0; i < WORDS; i++) m_mem[i] = 'hFFFF;
      qa.delete(); qd.delete();
      started = 1;
    end else begin
      m_rsp_v = rd_valid && !m_busy;
      if (m_rsp_v) begin
        if (rd_from_prog) m_rsp_d = m_sec ? 'h0098 : m_mem[rd_addr];
        else              m_rsp_d = fse ? 0 : m_mem[rd_addr];
      end
      m_done = 0;
      if (m_busy && !m_fail) begin
        m_e++;
        // op codes: 0 lock, 1 unlock, 2 wipe, 3 word
        if (m_e == STEP) begin
          if (m_op == 0) m_sec = 1;
          else if (m_op == 3) m_mem[m_widx] = m_wdat;
          else for (int i = 0; i < WORDS; i++) m_mem[i] = 'hFFFF;
        end
        if (m_e == 2*STEP || m_e == 4*STEP) begin
          if (fault_inj) m_fail = 1;
          else if (m_op != 1 || m_e == 4*STEP) begin m_busy = 0; m_done = 1; end
        end
        if (m_e == 3*STEP && m_op == 1) m_sec = 0;
      end else if (!m_busy && wr_valid) begin
        bit any;
        qa.push_back(int'(wr_addr)); qd.push_back(int'(wr_data));
        any = 0;
        for (int s = 0; s < 3; s++) begin
          if (is_prefix(s)) begin
            any = 1;
            if (qa.size() == seq_n[s]) begin
              if (s == 0 && fse) m_start(0);
              else if (s == 1) m_start(fse ? 1 : 2);
              else if (s == 2) begin m_widx = qa[3] % WORDS; m_wdat = qd[3]; m_start(3); end
              any = 0;
            end
          end
        end
        if (!any) begin qa.delete(); qd.delete(); end
      end
    end
  end

  always @(negedge clk) begin
    if (started) begin
      chk(cur_req, "busy", int'(busy), int'(m_busy));
      chk(cur_req, "done", int'(done), int'(m_done));
      chk(cur_req, "fail", int'(fail), int'(m_fail));
      chk(cur_req, "sec_on", int'(sec_on), int'(m_sec));
      chk("R14", "rd_ready", int'(rd_ready), int'(!m_busy));
      chk("R7", "wr_ready", int'(wr_ready), 1);
      chk(cur_req, "rsp_valid", int'(rsp_valid), int'(m_rsp_v));
      if (m_rsp_v) chk(cur_req, "rsp_data", int'(rsp_data), m_rsp_d);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(int a, int d);
    @(negedge clk);
    wr_valid = 1; wr_addr = ADDR_W'(a); wr_data = DATA_W'(d);
  endtask
  task automatic wr_end();
    @(negedge clk); wr_valid = 0;
  endtask
  task automatic rd(int idx, bit prog);
    @(negedge clk);
    rd_valid = 1; rd_addr = IDX_W'(idx); rd_from_prog = prog;
    @(negedge clk); rd_valid = 0;
  endtask
  task automatic wait_idle();
    do @(negedge clk); while (m_busy);
    @(negedge clk);
  endtask
  task automatic seq_word(int idx, int d);
    wr('h555,'hAA); wr('h2AA,'h55); wr('h555,'hA0); wr(idx, d); wr_end();
  endtask
  task automatic seq_lock();
    wr('h555,'hAA); wr('h2AA,'h55); wr('h555,'h50); wr('h555,'h20); wr_end();
  endtask
  task automatic seq_erase();
    wr('h555,'hAA); wr('h2AA,'h55); wr('h555,'h80);
    wr('h555,'hAA); wr('h2AA,'h55); wr('h555,'h10); wr_end();
  endtask
  task automatic do_reset();
    @(negedge clk); rst_n = 0; fault_inj = 0;
    repeat (2) @(negedge clk); rst_n = 1;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog expired after %0d cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    cur_req = "R13";
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R13", "busy after reset", int'(busy), 0);

    cur_req = "R6";  seq_word(3, 'h1234); wait_idle();
    cur_req = "R12"; rd(3, 0);
    cur_req = "R11"; rd(3, 1);

    cur_req = "R1"; fse = 1;
    wr('h555,'hAA); wr('h2AA,'h12); wr('h2AA,'h55); wr('h555,'h50); wr('h555,'h20); wr_end();
    repeat (3) @(negedge clk);
    chk("R1", "busy after broken sequence", int'(busy), 0);

    cur_req = "R3"; fse = 0; seq_lock(); repeat (3) @(negedge clk);
    chk("R3", "sec_on with fse low", int'(sec_on), 0);

    cur_req = "R2"; fse = 1; seq_lock();
    cur_req = "R7"; seq_word(5, 'h0000); seq_erase();
    cur_req = "R8"; wait_idle();
    chk("R2", "sec_on after lock", int'(sec_on), 1);
    cur_req = "R7"; fse = 0; rd(5, 0);

    cur_req = "R11"; rd(3, 1);
    cur_req = "R12"; fse = 1; rd(3, 0); fse = 0; rd(3, 0);

    cur_req = "R5"; fse = 0; seq_erase(); wait_idle();
    chk("R5", "sec_on after wipe", int'(sec_on), 1);
    rd(3, 0);

    cur_req = "R6"; seq_word(7, 'hABCD); wait_idle(); rd(7, 0);
    cur_req = "R4"; fse = 1; seq_erase(); wait_idle();
    chk("R4", "sec_on after unlock", int'(sec_on), 0);
    fse = 0; rd(7, 1); rd(7, 0);

    cur_req = "R9"; fault_inj = 1; seq_word(2, 'h5555);
    repeat (3*STEP) @(negedge clk);
    chk("R9", "fail stuck", int'(fail), 1);
    chk("R9", "busy stuck", int'(busy), 1);
    rd(2, 0);
    cur_req = "R13"; do_reset(); @(negedge clk);

    cur_req = "R10"; fse = 1; seq_lock(); wait_idle();
    fault_inj = 1; seq_erase();
    repeat (5*STEP) @(negedge clk);
    chk("R10", "sec_on kept after failed wipe", int'(sec_on), 1);
    chk("R10", "fail", int'(fail), 1);
    cur_req = "R13"; do_reset(); @(negedge clk);

    cur_req = "R13"; fse = 0; seq_word(4, 'h0F0F); wait_idle();
    fse = 1; seq_erase(); repeat (STEP + 2) @(negedge clk);
    do_reset(); @(negedge clk);
    chk("R13", "busy after abort", int'(busy), 0);
    fse = 0; rd(4, 0);

    cur_req = "R14"; rd(0, 1); repeat (2) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule